// File: doc/BRIEF.md
# Twin-Port Memory with Collision Arbitration

A 2048-word by 8-bit memory with two independent access ports, named left and right. Each port has an active-low select, a write strobe (low = write, high = read), an active-low read enable, an 11-bit address, write data, and registered read data with a valid flag. Writes take effect at the clock edge that ends the cycle in which they are presented. Read data and its valid flag appear one cycle after the read is presented.

When both ports are selected and point at the same word, an arbiter decides which port owns that word. It signals the other port with an active-low busy flag in the same cycle. A busy port cannot write. A busy port's read is flagged invalid while the owner is writing.

The `MASTER` parameter chooses how busy is produced. With `MASTER=1` the arbiter decides and drives the busy outputs. With `MASTER=0` the arbiter is left out: each port's busy input acts only as an external write inhibit, and both busy outputs stay high. This lets several memories share one arbitration decision when they are placed side by side for a wider word.

The arbiter is a three-state machine:
- States: `ARB_FREE` (no collision held), `ARB_LEFT_OWNS` (right busy), `ARB_RIGHT_OWNS` (left busy).
- Transitions:
  - `FREE->LEFT_OWNS` on a collision that the left port wins.
  - `FREE->RIGHT_OWNS` on a collision that the right port wins.
  - `LEFT_OWNS->LEFT_OWNS` and `RIGHT_OWNS->RIGHT_OWNS` while the collision persists.
  - `*->FREE` as soon as the addresses differ or either select goes high.

Top module: `dpr_twin_ram`

## Requirements
- R1: A port with select low and write strobe low writes its write data to its address at the clock edge, unless its busy is low. A port with select low, write strobe high and read enable low returns the word at its address on its read data output one cycle later, with the valid flag high.
- R2: Nothing is written by a port whose select is high. The valid flag is low in the cycle after a cycle in which that port's select was high, its write strobe was low, or its read enable was high.
- R3: In master mode, both busy outputs are high in any cycle where either select is high or the two addresses differ.
- R4: A collision is both selects low with equal addresses. On a collision starting from `ARB_FREE`, the winner is the port whose select and address were already the same in the previous cycle. If both ports were already stable, or both have just arrived, the left port wins. The loser's busy output goes low in that same cycle.
- R5: The two busy outputs are never low in the same cycle.
- R6: The write strobes play no part in the arbitration decision. A reading port that arrived first wins against a writing port.
- R7: While a collision persists, the same port keeps ownership. Busy returns high in the first cycle in which the collision ends.
- R8: A write presented by a port whose busy is low leaves the memory unchanged.
- R9: A read on a busy port while the owning port writes gives a low valid flag in the next cycle. When both colliding ports only read, both reads are valid and return the stored word.
- R10: After the owner's write, a read of that word by the former loser, presented in the following cycle, returns the newly written data.
- R11: In slave mode, both busy outputs stay high, no arbitration takes place, and a low level on a port's busy input blocks that port's writes.
- R12: In slave mode, if both ports write the same word in one cycle with their busy inputs high, the left port's data is kept.
- R13: While reset is low: both valid flags are low, both busy outputs are high, no write reaches the memory, and the arbiter returns to `ARB_FREE`. The memory contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_sel_n | input | 1 | Left port select, active low |
| lt_wr_n | input | 1 | Left write strobe: 0 write, 1 read |
| lt_oe_n | input | 1 | Left read enable, active low |
| lt_addr | input | 11 | Left word address |
| lt_wdata | input | 8 | Left write data |
| lt_rdata | output | 8 | Left registered read data |
| lt_rvalid | output | 1 | Left read data valid |
| lt_busy_in_n | input | 1 | Left external write inhibit, active low (slave mode only) |
| lt_busy_out_n | output | 1 | Left busy flag, active low (master mode only, else high) |
| rt_sel_n | input | 1 | Right port select, active low |
| rt_wr_n | input | 1 | Right write strobe: 0 write, 1 read |
| rt_oe_n | input | 1 | Right read enable, active low |
| rt_addr | input | 11 | Right word address |
| rt_wdata | input | 8 | Right write data |
| rt_rdata | output | 8 | Right registered read data |
| rt_rvalid | output | 1 | Right read data valid |
| rt_busy_in_n | input | 1 | Right external write inhibit, active low (slave mode only) |
| rt_busy_out_n | output | 1 | Right busy flag, active low (master mode only, else high) |

## Verification
The bench builds two copies of the block side by side, one with `MASTER=1` and one with `MASTER=0`, both at the default 11-bit address and 8-bit data widths. The two copies see the same port traffic. The slave copy additionally receives busy inputs driven by the bench.

Running both copies together makes it possible to compare, within one run, a write that the arbiter suppresses against the same write landing in the slave copy, and a slave write blocked by an external inhibit against the master copy completing it. The full memory is preloaded through both ports at once, so every read can be compared against a known value.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // Ownership of a colliding word, held by the arbiter across cycles.
    typedef enum logic [1:0] {
        ARB_FREE       = 2'd0,
        ARB_LEFT_OWNS  = 2'd1,
        ARB_RIGHT_OWNS = 2'd2
    } arb_state_t;

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_busy_n,
    output logic              r_busy_n
);

    arb_state_t        state_q;
    arb_state_t        state_d;
    logic              l_en_q;
    logic              r_en_q;
    logic [ADDR_W-1:0] l_addr_q;
    logic [ADDR_W-1:0] r_addr_q;
    logic              hit;
    logic              l_held;
    logic              r_held;
    logic              right_first;

    // Collision and arrival order, from this cycle's inputs and last cycle's.
    always_comb begin
        hit         = l_en && r_en && (l_addr == r_addr);
        l_held      = l_en_q && l_en && (l_addr_q == l_addr);
        r_held      = r_en_q && r_en && (r_addr_q == r_addr);
        right_first = r_held && !l_held;
    end

    // History of each port's select and address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_en_q   <= 1'b0;
            r_en_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            l_en_q   <= l_en;
            r_en_q   <= r_en;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_FREE: begin
                if (hit) begin
                    state_d = right_first ? ARB_RIGHT_OWNS : ARB_LEFT_OWNS;
                end
            end
            ARB_LEFT_OWNS, ARB_RIGHT_OWNS: begin
                if (!hit) begin
                    state_d = ARB_FREE;
                end
            end
            default: state_d = ARB_FREE;
        endcase
    end

    // Busy outputs: decided in the cycle the collision is seen.
    always_comb begin
        l_busy_n = 1'b1;
        r_busy_n = 1'b1;
        if (rst_n && hit) begin
            unique case (state_q)
                ARB_FREE: begin
                    if (right_first) begin
                        l_busy_n = 1'b0;
                    end else begin
                        r_busy_n = 1'b0;
                    end
                end
                ARB_LEFT_OWNS:  r_busy_n = 1'b0;
                ARB_RIGHT_OWNS: l_busy_n = 1'b0;
                default: begin
                    l_busy_n = 1'b1;
                    r_busy_n = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic wr_n,
    input  logic oe_n,
    input  logic busy_n,
    input  logic peer_wen,
    output logic wen,
    output logic ren,
    output logic rvalid
);

    logic rd_ok;

    always_comb begin
        wen   = rst_n && !sel_n && !wr_n && busy_n;
        ren   = !sel_n && wr_n;
        rd_ok = ren && !oe_n && !(!busy_n && peer_wen);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_ok;
        end
    end

endmodule

// File: rtl/dpr_storage.sv
module dpr_storage #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              a_wen,
    input  logic              a_ren,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_wen,
    input  logic              b_ren,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              b_shadowed;

    // Port a takes precedence when both write the same word.
    always_comb b_shadowed = a_wen && (a_addr == b_addr);

    always_ff @(posedge clk) begin
        if (a_wen) begin
            mem[a_addr] <= a_wdata;
        end
        if (b_wen && !b_shadowed) begin
            mem[b_addr] <= b_wdata;
        end
        if (a_ren) begin
            a_rdata <= mem[a_addr];
        end
        if (b_ren) begin
            b_rdata <= mem[b_addr];
        end
    end

endmodule

// File: rtl/dpr_twin_ram.sv
module dpr_twin_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter bit MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_sel_n,
    input  logic              lt_wr_n,
    input  logic              lt_oe_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [DATA_W-1:0] lt_wdata,
    output logic [DATA_W-1:0] lt_rdata,
    output logic              lt_rvalid,
    input  logic              lt_busy_in_n,
    output logic              lt_busy_out_n,
    input  logic              rt_sel_n,
    input  logic              rt_wr_n,
    input  logic              rt_oe_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata,
    output logic              rt_rvalid,
    input  logic              rt_busy_in_n,
    output logic              rt_busy_out_n
);

    logic l_busy_eff_n;
    logic r_busy_eff_n;
    logic l_wen;
    logic r_wen;
    logic l_ren;
    logic r_ren;

    generate
        if (MASTER) begin : g_master
            logic l_arb_busy_n;
            logic r_arb_busy_n;

            dpr_arbiter #(
                .ADDR_W (ADDR_W)
            ) i_arb (
                .clk      (clk),
                .rst_n    (rst_n),
                .l_en     (!lt_sel_n),
                .r_en     (!rt_sel_n),
                .l_addr   (lt_addr),
                .r_addr   (rt_addr),
                .l_busy_n (l_arb_busy_n),
                .r_busy_n (r_arb_busy_n)
            );

            assign l_busy_eff_n  = l_arb_busy_n;
            assign r_busy_eff_n  = r_arb_busy_n;
            assign lt_busy_out_n = l_arb_busy_n;
            assign rt_busy_out_n = r_arb_busy_n;
        end else begin : g_slave
            assign l_busy_eff_n  = lt_busy_in_n;
            assign r_busy_eff_n  = rt_busy_in_n;
            assign lt_busy_out_n = 1'b1;
            assign rt_busy_out_n = 1'b1;
        end
    endgenerate

    dpr_port_ctrl i_lt_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (lt_sel_n),
        .wr_n     (lt_wr_n),
        .oe_n     (lt_oe_n),
        .busy_n   (l_busy_eff_n),
        .peer_wen (r_wen),
        .wen      (l_wen),
        .ren      (l_ren),
        .rvalid   (lt_rvalid)
    );

    dpr_port_ctrl i_rt_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (rt_sel_n),
        .wr_n     (rt_wr_n),
        .oe_n     (rt_oe_n),
        .busy_n   (r_busy_eff_n),
        .peer_wen (l_wen),
        .wen      (r_wen),
        .ren      (r_ren),
        .rvalid   (rt_rvalid)
    );

    dpr_storage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_mem (
        .clk     (clk),
        .a_wen   (l_wen),
        .a_ren   (l_ren),
        .a_addr  (lt_addr),
        .a_wdata (lt_wdata),
        .a_rdata (lt_rdata),
        .b_wen   (r_wen),
        .b_ren   (r_ren),
        .b_addr  (rt_addr),
        .b_wdata (rt_wdata),
        .b_rdata (rt_rdata)
    );

endmodule

// File: rtl/dpr_twin_ram_chk.sv
module dpr_twin_ram_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter bit MASTER = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lt_sel_n,
    input logic              lt_wr_n,
    input logic              lt_oe_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              lt_rvalid,
    input logic              lt_busy_out_n,
    input logic              rt_sel_n,
    input logic              rt_wr_n,
    input logic              rt_oe_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_rvalid,
    input logic              rt_busy_out_n
);

    logic collide;
    assign collide = !lt_sel_n && !rt_sel_n && (lt_addr == rt_addr);

    // R5
    both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lt_busy_out_n && !rt_busy_out_n));

    // R2
    lt_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lt_rvalid |-> $past(!lt_sel_n && lt_wr_n && !lt_oe_n));

    // R2
    rt_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_rvalid |-> $past(!rt_sel_n && rt_wr_n && !rt_oe_n));

    generate
        if (MASTER) begin : g_master_chk
            // R3
            idle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !collide |-> (lt_busy_out_n && rt_busy_out_n));

            // R7
            grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!rt_busy_out_n && collide) |=> (collide |-> !rt_busy_out_n));

            // R9
            busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!lt_busy_out_n && !rt_sel_n && !rt_wr_n) |=> !lt_rvalid);
        end else begin : g_slave_chk
            // R11
            slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                lt_busy_out_n && rt_busy_out_n);
        end
    endgenerate

endmodule

bind dpr_twin_ram dpr_twin_ram_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MASTER (MASTER)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lt_sel_n      (lt_sel_n),
    .lt_wr_n       (lt_wr_n),
    .lt_oe_n       (lt_oe_n),
    .lt_addr       (lt_addr),
    .lt_rvalid     (lt_rvalid),
    .lt_busy_out_n (lt_busy_out_n),
    .rt_sel_n      (rt_sel_n),
    .rt_wr_n       (rt_wr_n),
    .rt_oe_n       (rt_oe_n),
    .rt_addr       (rt_addr),
    .rt_rvalid     (rt_rvalid),
    .rt_busy_out_n (rt_busy_out_n)
);

// File: tb/test_dpr_twin_ram.sv
module test_dpr_twin_ram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ls = 1'b1, lw = 1'b1, lo = 1'b1;
    logic        rs = 1'b1, rw = 1'b1, ro = 1'b1;
    logic [10:0] la = '0, ra = '0;
    logic [7:0]  ld = '0, rd = '0;
    logic        s_lbi = 1'b1, s_rbi = 1'b1;

    logic [7:0] m_lrd, m_rrd, s_lrd, s_rrd;
    logic       m_lrv, m_rrv, s_lrv, s_rrv;
    logic       m_lbo, m_rbo, s_lbo, s_rbo;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dpr_twin_ram #(.MASTER(1'b1)) i_dpr_twin_ram (
        .clk(clk), .rst_n(rst_n),
        .lt_sel_n(ls), .lt_wr_n(lw), .lt_oe_n(lo), .lt_addr(la), .lt_wdata(ld),
        .lt_rdata(m_lrd), .lt_rvalid(m_lrv), .lt_busy_in_n(1'b1), .lt_busy_out_n(m_lbo),
        .rt_sel_n(rs), .rt_wr_n(rw), .rt_oe_n(ro), .rt_addr(ra), .rt_wdata(rd),
        .rt_rdata(m_rrd), .rt_rvalid(m_rrv), .rt_busy_in_n(1'b1), .rt_busy_out_n(m_rbo)
    );

    dpr_twin_ram #(.MASTER(1'b0)) i_dpr_twin_ram_slave (
        .clk(clk), .rst_n(rst_n),
        .lt_sel_n(ls), .lt_wr_n(lw), .lt_oe_n(lo), .lt_addr(la), .lt_wdata(ld),
        .lt_rdata(s_lrd), .lt_rvalid(s_lrv), .lt_busy_in_n(s_lbi), .lt_busy_out_n(s_lbo),
        .rt_sel_n(rs), .rt_wr_n(rw), .rt_oe_n(ro), .rt_addr(ra), .rt_wdata(rd),
        .rt_rdata(s_rrd), .rt_rvalid(s_rrv), .rt_busy_in_n(s_rbi), .rt_busy_out_n(s_rbo)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] mref [2][2048];
    int         owner = 0;          // 0 none, 1 left owns, 2 right owns
    bit         pl_en = 0, pr_en = 0;
    logic [10:0] pla = '0, pra = '0;
    logic [7:0] xl_d [2];
    logic [7:0] xr_d [2];
    bit         xl_v [2] = '{0, 0};
    bit         xr_v [2] = '{0, 0};

    task automatic model_step();
        bit en_l, en_r, hit, lh, rh, wl, wr;
        bit bl [2];
        bit br [2];
        logic [7:0] ard, ardr;
        logic       arv, arvr;
        if (!rst_n) begin
            chk("R13 master lt busy in reset", m_lbo, 1);
            chk("R13 master rt busy in reset", m_rbo, 1);
            chk("R13 lt rvalid in reset", m_lrv, 0);
            chk("R13 rt rvalid in reset", s_rrv, 0);
            owner = 0; pl_en = 0; pr_en = 0;
            xl_v = '{0, 0}; xr_v = '{0, 0};
            return;
        end
        en_l = !ls; en_r = !rs;
        hit = en_l && en_r && (la == ra);
        bl[0] = 1; br[0] = 1;
        if (hit) begin
            if (owner == 1) br[0] = 0;
            else if (owner == 2) bl[0] = 0;
            else begin
                lh = pl_en && (pla == la);
                rh = pr_en && (pra == ra);
                if (rh && !lh) bl[0] = 0; else br[0] = 0;
            end
        end
        bl[1] = s_lbi; br[1] = s_rbi;
        chk("R4 master lt busy", m_lbo, bl[0]);
        chk("R4 master rt busy", m_rbo, br[0]);
        chk("R5 busy never both low", (!m_lbo && !m_rbo), 0);
        chk("R11 slave lt busy out", s_lbo, 1);
        chk("R11 slave rt busy out", s_rbo, 1);
        for (int k = 0; k < 2; k++) begin
            arv  = (k == 0) ? m_lrv : s_lrv;
            ard  = (k == 0) ? m_lrd : s_lrd;
            arvr = (k == 0) ? m_rrv : s_rrv;
            ardr = (k == 0) ? m_rrd : s_rrd;
            chk("R9 lt rvalid", arv, xl_v[k]);
            if (xl_v[k]) chk("R1 lt rdata", ard, xl_d[k]);
            chk("R9 rt rvalid", arvr, xr_v[k]);
            if (xr_v[k]) chk("R1 rt rdata", ardr, xr_d[k]);
        end
        if (!hit) owner = 0;
        else if (owner == 0) owner = bl[0] ? 1 : 2;
        for (int k = 0; k < 2; k++) begin
            wl = en_l && !lw && bl[k];
            wr = en_r && !rw && br[k];
            xl_v[k] = en_l && lw && !lo && !(!bl[k] && wr);
            xr_v[k] = en_r && rw && !ro && !(!br[k] && wl);
            xl_d[k] = mref[k][la];
            xr_d[k] = mref[k][ra];
            if (wr) mref[k][ra] = rd;
            if (wl) mref[k][la] = ld;   // left kept on a same-word double write
        end
        pl_en = en_l; pla = la; pr_en = en_r; pra = ra;
    endtask

    always @(negedge clk) begin
        #4;
        if (!done) model_step();
    end

    // ---------------- stimulus ----------------
    task automatic drv(input logic s0, input logic w0, input logic o0, input int a0, input int d0,
                       input logic s1, input logic w1, input logic o1, input int a1, input int d1);
        @(negedge clk);
        ls = s0; lw = w0; lo = o0; la = a0[10:0]; ld = d0[7:0];
        rs = s1; rw = w1; ro = o1; ra = a1[10:0]; rd = d1[7:0];
    endtask

    task automatic idle();
        drv(1, 1, 1, 0, 0, 1, 1, 1, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R13: reset state
        repeat (3) @(negedge clk);
        #3;
        chk("R13 lt rvalid low", m_lrv, 0);
        chk("R13 busy high", {m_lbo, m_rbo}, 2'b11);
        @(negedge clk);
        rst_n = 1'b1;

        // Preload every word through both ports at once (R1)
        for (int i = 0; i < 1024; i++) begin
            drv(0, 0, 1, 2 * i, ((2 * i) & 8'hFF) ^ 8'h5A,
                0, 0, 1, 2 * i + 1, ((2 * i + 1) & 8'hFF) ^ 8'h5A);
        end

        // R1/R3: independent writes, then reads
        drv(0, 0, 1, 5, 8'hA5, 0, 0, 1, 100, 8'h3C);
        #3 chk("R3 no collision busy", {m_lbo, m_rbo}, 2'b11);
        drv(0, 1, 0, 5, 0, 0, 1, 0, 100, 0);
        idle();
        #3;
        chk("R1 lt read back", m_lrd, 8'hA5);
        chk("R1 lt rvalid", m_lrv, 1);
        chk("R1 rt read back", m_rrd, 8'h3C);

        // R4/R6/R8: right reading first wins against a later left write
        drv(1, 1, 1, 0, 0, 0, 1, 0, 7, 0);
        drv(0, 0, 1, 7, 8'h11, 0, 1, 0, 7, 0);
        #3;
        chk("R4 late left is busy", m_lbo, 0);
        chk("R6 reading right wins", m_rbo, 1);
        drv(0, 1, 0, 7, 0, 1, 1, 1, 0, 0);
        idle();
        #3;
        chk("R8 suppressed write left word", m_lrd, 8'h5D);
        chk("R11 slave took the write", s_lrd, 8'h11);

        // R4 tie, R7 hold, R9 both reading, R12 slave double write
        drv(0, 0, 1, 9, 8'hAA, 0, 0, 1, 9, 8'hBB);
        #3;
        chk("R4 tie goes left", {m_lbo, m_rbo}, 2'b10);
        drv(0, 1, 0, 9, 0, 0, 1, 0, 9, 0);
        #3 chk("R7 owner kept", m_rbo, 0);
        idle();
        #3;
        chk("R9 busy read valid when both read", m_rrv, 1);
        chk("R9 busy read data", m_rrd, 8'hAA);
        chk("R12 slave left kept", s_lrd, 8'hAA);

        // R9 invalid read during owner write, R10 new data next
        drv(0, 0, 1, 20, 8'h3C, 0, 1, 0, 20, 0);
        drv(0, 1, 0, 20, 0, 0, 1, 0, 20, 0);
        #3 chk("R9 busy read invalid", m_rrv, 0);
        idle();
        #3;
        chk("R10 loser sees new data", m_rrd, 8'h3C);
        chk("R10 loser rvalid", m_rrv, 1);

        // R7 release
        drv(0, 1, 0, 50, 0, 0, 1, 0, 50, 0);
        #3 chk("R7 collision busy", m_rbo, 0);
        drv(0, 1, 0, 50, 0, 0, 1, 0, 51, 0);
        #3 chk("R7 release same cycle", {m_lbo, m_rbo}, 2'b11);

        // R2: deselected write, read enable high
        drv(1, 0, 1, 30, 8'hFF, 1, 1, 1, 0, 0);
        drv(0, 1, 1, 30, 0, 1, 1, 1, 0, 0);
        drv(0, 1, 0, 30, 0, 1, 1, 1, 0, 0);
        #3 chk("R2 rvalid low with read enable high", m_lrv, 0);
        idle();
        #3;
        chk("R2 deselected write ignored", m_lrd, 8'h44);
        chk("R2 rvalid", m_lrv, 1);

        // R11: slave write inhibit input
        s_lbi = 1'b0;
        drv(0, 0, 1, 40, 8'h99, 1, 1, 1, 0, 0);
        #3 chk("R11 slave busy out stays high", {s_lbo, s_rbo}, 2'b11);
        drv(0, 1, 0, 40, 0, 1, 1, 1, 0, 0);
        s_lbi = 1'b1;
        idle();
        #3;
        chk("R11 master wrote", m_lrd, 8'h99);
        chk("R11 slave inhibited", s_lrd, 8'h72);

        repeat (3) idle();
        finish_run();
    end

endmodule